// File: doc/BRIEF.md
# Source Driver Horizontal Timing Generator

This block drives the horizontal control pins of an analog-input, delta-pixel TFT panel's column driver. A horizontal sync pulse starts each line. From the master clock the block makes a sampling period out of six equal sub-phases. The length of each sub-phase is set by a divider input. Three sampling clocks come out, each running at half duty and each lagging the previous one by a third of a period. The line lasts a fixed number of sampling periods and restarts on every sync rising edge. If no new sync arrives, the line counter wraps and runs freely.

Within each line the block places a start pulse one sampling period wide. The pulse is centred on a rising edge of the first sampling clock, and it is routed to one of two bidirectional start pins according to the scan direction. The block also places an output-enable window for the column driver. It keeps a polarity bit that flips on every line. That bit drives both the common-electrode polarity flag and the colour-rotation control. Scan direction and divider setting are captured only when a line starts, so software or upstream logic can change them at any time without tearing the current line.

All outputs come from registers. The decode of "position n" is the state reached n master clocks after the clock edge that detects the sync rising edge. That decode appears at the outputs one clock edge after it is reached.

Top module: `lt_src_line_gen`

## Requirements
- R1: While reset is low and after it, until the first rising edge of `hd`, all outputs are 0, including both pin enables and the polarity bits.
- R2: A rising edge of `hd` restarts the line at position 0, even in the middle of a line. The outputs for position n (n master clocks after the detecting edge) are visible after the following clock edge.
- R3: With D = `phase_len_m1`+1, a sampling period is 6·D clocks, and the sub-phase at position n is s = (n/D) mod 6. `cph1` is high for s in {0,1,2}, `cph2` for s in {2,3,4} and `cph3` for s in {4,5,0}, so each clock has equal high and low times and lags the previous one by 2·D clocks.
- R4: The sampling-period counter p = n/(6·D) wraps from LINE_LEN−1 (default 100 periods per line) to 0 when no new `hd` edge arrives, and the pattern repeats.
- R5: The start pulse is high from sub-phase 3 of period STH_POS−1 through sub-phase 2 of period STH_POS (default 16). It is therefore 6·D clocks wide and has 3·D clocks of setup and of hold around the `cph1` rise.
- R6: With `scan_lr`=1, `sth1_oe`=1 and `sth1_o` carries the start pulse, while `sth2_oe`=0 and `sth2_o`=0. With `scan_lr`=0, the roles of the two pins swap.
- R7: `inh` is high during periods INH_START to INH_START+INH_LEN−1 (defaults 2 and 6) and low for the rest of the line.
- R8: `vcom_pol` and `q2h` are equal. They are 0 after reset and invert on every rising edge of `hd`, becoming visible one clock after the detecting edge.
- R9: `scan_lr` and `phase_len_m1` are sampled only at a rising edge of `hd`. Changes during a line do not alter that line's outputs.
- R10: Holding `hd` high does not restart the line. Only a 0-to-1 transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hd | input | 1 | Horizontal sync, synchronous to `clk`; rising edge starts a line |
| scan_lr | input | 1 | Scan direction: 1 selects pin 1 as start output, 0 selects pin 2 |
| phase_len_m1 | input | DIV_W | Master clocks per sub-phase minus one |
| cph1 | output | 1 | Sampling clock, phase 1 |
| cph2 | output | 1 | Sampling clock, phase 2 (lags phase 1 by a third of a period) |
| cph3 | output | 1 | Sampling clock, phase 3 (lags phase 2 by a third of a period) |
| sth1_o | output | 1 | Start pulse value for bidirectional pin 1 |
| sth1_oe | output | 1 | Drive enable for pin 1 |
| sth2_o | output | 1 | Start pulse value for bidirectional pin 2 |
| sth2_oe | output | 1 | Drive enable for pin 2 |
| inh | output | 1 | Column driver output-enable window |
| q2h | output | 1 | Colour-rotation control, inverts each line |
| vcom_pol | output | 1 | Common-electrode polarity flag, inverts each line |

## Verification
The assertions assume that `hd` is synchronous to `clk` and low during reset. The phase-order checks also assume that a restart is the only event that can break the sub-phase sequence, so they are masked for the two clocks that follow an `hd` rising edge. The stimulus drives `hd`, `scan_lr` and `phase_len_m1` only on falling clock edges. It keeps every line that it checks long enough for the phase order to settle, and it raises `hd` only from a low level except in the deliberate held-high case. Divider settings stay small, so that complete lines, including the wrap past the last period, fit in a short run.

// File: rtl/lt_pkg.sv
// Shared constants and types for the source-driver line timing generator.
// Assumes a sampling period made of six equal sub-phases and three clock phases.
package lt_pkg;
    localparam int SUBPH   = 6;              // sub-phases per sampling period
    localparam int NPH     = 3;              // number of sampling clocks
    localparam int PH_STEP = SUBPH / NPH;    // sub-phase lag between clocks
    localparam int PH_HIGH = SUBPH / 2;      // sub-phases each clock stays high

    typedef logic [2:0] subph_t;

    // Registered output bundle handed from the decoder to the top level.
    typedef struct packed {
        logic [NPH-1:0] cph;     // bit 0 = phase 1
        logic [1:0]     st_o;    // bit 0 = pin 1
        logic [1:0]     st_oe;   // bit 0 = pin 1
        logic           inh;
        logic           pol;
    } hout_t;
endpackage

// File: rtl/lt_line_state.sv
// Line-level state: detects the sync rising edge and captures the per-line settings.
// It also keeps the polarity bit that inverts on every line.
// Assumes hd is already synchronous to clk.
module lt_line_state #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hd,
    input  logic             scan_lr,
    input  logic [DIV_W-1:0] phase_len_m1,
    output logic             hd_rise,
    output logic             lr_q,
    output logic [DIV_W-1:0] div_q,
    output logic             pol_q
);
    logic hd_q;

    // Remember last sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hd_q <= 1'b0;
        else        hd_q <= hd;
    end

    assign hd_rise = hd & ~hd_q;

    // Capture direction and divider at line start, and flip polarity per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_q  <= 1'b1;
            div_q <= '0;
            pol_q <= 1'b0;
        end else if (hd_rise) begin
            lr_q  <= scan_lr;
            div_q <= phase_len_m1;
            pol_q <= ~pol_q;
        end
    end
endmodule

// File: rtl/lt_phase_seq.sv
// Position sequencer: master-clock divider, sub-phase counter and sampling-period counter.
// Idle after reset until the first line start. Restarts at position 0 on each sync edge.
// The period counter wraps at LINE_LEN.
module lt_phase_seq
    import lt_pkg::*;
#(
    parameter int DIV_W    = 6,
    parameter int LINE_LEN = 100,
    parameter int PIX_W    = $clog2(LINE_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hd_rise,
    input  logic [DIV_W-1:0] div_q,
    output logic             running,
    output subph_t           sub,
    output logic [PIX_W-1:0] pix
);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE_LEN - 1);
    localparam subph_t           SUB_LAST = subph_t'(SUBPH - 1);

    logic [DIV_W-1:0] cnt;

    // Advance divider, sub-phase and period counters; restart on line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            sub     <= '0;
            pix     <= '0;
        end else if (hd_rise) begin
            running <= 1'b1;
            cnt     <= '0;
            sub     <= '0;
            pix     <= '0;
        end else if (running) begin
            if (cnt == div_q) begin
                cnt <= '0;
                if (sub == SUB_LAST) begin
                    sub <= '0;
                    pix <= (pix == PIX_LAST) ? '0 : pix + 1'b1;
                end else begin
                    sub <= sub + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lt_out_decode.sv
// Decodes the sequencer position into the sampling clocks, start pulse, steering and
// output-enable window, and registers them together with the polarity bit.
// Assumes 1 <= STH_POS < LINE_LEN and INH_START >= 1.
module lt_out_decode
    import lt_pkg::*;
#(
    parameter int LINE_LEN  = 100,
    parameter int PIX_W     = $clog2(LINE_LEN),
    parameter int STH_POS   = 16,
    parameter int INH_START = 2,
    parameter int INH_LEN   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  subph_t           sub,
    input  logic [PIX_W-1:0] pix,
    input  logic             lr_q,
    input  logic             pol_q,
    output hout_t            q
);
    localparam logic [PIX_W-1:0] STH_PRE = PIX_W'(STH_POS - 1);
    localparam logic [PIX_W-1:0] STH_AT  = PIX_W'(STH_POS);
    localparam logic [PIX_W-1:0] INH_LO  = PIX_W'(INH_START);
    localparam logic [PIX_W:0]   INH_HI  = (PIX_W+1)'(INH_START + INH_LEN);

    logic [NPH-1:0] cph_n;
    logic [1:0]     drv;
    logic           sth_n;
    logic           inh_n;

    // One half-duty decode per sampling clock, each lagging by PH_STEP sub-phases.
    for (genvar i = 0; i < NPH; i++) begin : g_ph
        logic [3:0] rel;
        // Sub-phase relative to this clock's own rising point.
        always_comb begin
            rel = {1'b0, sub} + 4'(SUBPH - i * PH_STEP);
            if (rel >= 4'(SUBPH)) rel = rel - 4'(SUBPH);
        end
        assign cph_n[i] = running && (rel < 4'(PH_HIGH));
    end

    // Start pulse straddles the phase-1 rise that opens period STH_POS.
    assign sth_n = (pix == STH_PRE && sub >= subph_t'(PH_HIGH)) ||
                   (pix == STH_AT  && sub <  subph_t'(PH_HIGH));

    // Output-enable window over a range of sampling periods.
    assign inh_n = running && (pix >= INH_LO) && ({1'b0, pix} < INH_HI);

    // Pin steering: pin 1 drives for left-to-right, pin 2 for right-to-left.
    for (genvar j = 0; j < 2; j++) begin : g_pin
        assign drv[j] = running && ((j == 0) ? lr_q : ~lr_q);
    end

    // Register every pin output so no decode glitch reaches the panel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q.cph   <= cph_n;
            q.st_oe <= drv;
            q.st_o  <= drv & {2{sth_n}};
            q.inh   <= inh_n;
            q.pol   <= pol_q;
        end
    end
endmodule

// File: rtl/lt_src_line_gen.sv
// Top level of the source-driver horizontal timing generator.
// Ties line state, position sequencer and output decoder together.
// Assumes hd is synchronous to clk.
module lt_src_line_gen
    import lt_pkg::*;
#(
    parameter int DIV_W     = 6,
    parameter int LINE_LEN  = 100,
    parameter int STH_POS   = 16,
    parameter int INH_START = 2,
    parameter int INH_LEN   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hd,
    input  logic             scan_lr,
    input  logic [DIV_W-1:0] phase_len_m1,
    output logic             cph1,
    output logic             cph2,
    output logic             cph3,
    output logic             sth1_o,
    output logic             sth1_oe,
    output logic             sth2_o,
    output logic             sth2_oe,
    output logic             inh,
    output logic             q2h,
    output logic             vcom_pol
);
    localparam int PIX_W = $clog2(LINE_LEN);

    logic             hd_rise;
    logic             lr_q;
    logic [DIV_W-1:0] div_q;
    logic             pol_q;
    logic             running;
    subph_t           sub;
    logic [PIX_W-1:0] pix;
    hout_t            hq;

    lt_line_state #(.DIV_W(DIV_W)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .hd           (hd),
        .scan_lr      (scan_lr),
        .phase_len_m1 (phase_len_m1),
        .hd_rise      (hd_rise),
        .lr_q         (lr_q),
        .div_q        (div_q),
        .pol_q        (pol_q)
    );

    lt_phase_seq #(.DIV_W(DIV_W), .LINE_LEN(LINE_LEN), .PIX_W(PIX_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hd_rise (hd_rise),
        .div_q   (div_q),
        .running (running),
        .sub     (sub),
        .pix     (pix)
    );

    lt_out_decode #(
        .LINE_LEN  (LINE_LEN),
        .PIX_W     (PIX_W),
        .STH_POS   (STH_POS),
        .INH_START (INH_START),
        .INH_LEN   (INH_LEN)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .sub     (sub),
        .pix     (pix),
        .lr_q    (lr_q),
        .pol_q   (pol_q),
        .q       (hq)
    );

    assign cph1     = hq.cph[0];
    assign cph2     = hq.cph[1];
    assign cph3     = hq.cph[2];
    assign sth1_o   = hq.st_o[0];
    assign sth1_oe  = hq.st_oe[0];
    assign sth2_o   = hq.st_o[1];
    assign sth2_oe  = hq.st_oe[1];
    assign inh      = hq.inh;
    assign q2h      = hq.pol;
    assign vcom_pol = hq.pol;
endmodule

// File: rtl/lt_src_line_gen_chk.sv
// Port-level property checker for the line timing generator, bound into the top.
// Assumes hd is low during reset.
module lt_src_line_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic hd,
    input logic cph1,
    input logic cph2,
    input logic cph3,
    input logic sth1_o,
    input logic sth1_oe,
    input logic sth2_o,
    input logic sth2_oe,
    input logic inh,
    input logic vcom_pol
);
    // R1: no pin is driven or toggling before a line has started.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(sth1_oe || sth2_oe) |-> ({cph1, cph2, cph3, inh, sth1_o, sth2_o} == 6'b0));

    // R6: at most one start pin is driven.
    a_r6_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sth1_oe, sth2_oe}));

    // R6: an undriven pin carries no pulse.
    a_r6_pin1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sth1_oe |-> !sth1_o);
    a_r6_pin2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sth2_oe |-> !sth2_o);

    // R3: while running, one or two sampling clocks are high, never none or all.
    a_r3_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (sth1_oe || sth2_oe) |-> ($countones({cph1, cph2, cph3}) >= 1 &&
                                  $countones({cph1, cph2, cph3}) <= 2));

    // R3: phase order outside restarts: 2 rises while 1 is high, 3 while 2, 1 while 3.
    a_r3_order2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cph2) && $past(sth1_oe || sth2_oe) && !($past(hd, 2) && !$past(hd, 3)))
        |-> (cph1 && !cph3));
    a_r3_order3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cph3) && $past(sth1_oe || sth2_oe) && !($past(hd, 2) && !$past(hd, 3)))
        |-> (cph2 && !cph1));

    // R8: the polarity flag changes only as a consequence of a sync rising edge.
    a_r8_pol_on_hd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vcom_pol) |-> ($past(hd, 2) && !$past(hd, 3)));
endmodule

bind lt_src_line_gen lt_src_line_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hd       (hd),
    .cph1     (cph1),
    .cph2     (cph2),
    .cph3     (cph3),
    .sth1_o   (sth1_o),
    .sth1_oe  (sth1_oe),
    .sth2_o   (sth2_o),
    .sth2_oe  (sth2_oe),
    .inh      (inh),
    .vcom_pol (vcom_pol)
);

// File: tb/lt_src_line_gen_tb.sv
module lt_src_line_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 6;
    localparam int LINE_LEN   = 100;
    localparam int STH_POS    = 16;
    localparam int INH_START  = 2;
    localparam int INH_LEN    = 6;

    logic clk, rst_n, hd, scan_lr;
    logic [DIV_W-1:0] phase_len_m1;
    logic cph1, cph2, cph3, sth1_o, sth1_oe, sth2_o, sth2_oe, inh, q2h, vcom_pol;

    lt_src_line_gen #(
        .DIV_W(DIV_W), .LINE_LEN(LINE_LEN), .STH_POS(STH_POS),
        .INH_START(INH_START), .INH_LEN(INH_LEN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .hd(hd), .scan_lr(scan_lr),
        .phase_len_m1(phase_len_m1),
        .cph1(cph1), .cph2(cph2), .cph3(cph3),
        .sth1_o(sth1_o), .sth1_oe(sth1_oe), .sth2_o(sth2_o), .sth2_oe(sth2_oe),
        .inh(inh), .q2h(q2h), .vcom_pol(vcom_pol)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int lines = 0;

    // Stimulus / expected table: divider, direction, expected {sth1_oe, sth2_oe}.
    typedef struct packed {
        logic [DIV_W-1:0] div_m1;
        logic             lr;
        logic [1:0]       oe;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{6'd0, 1'b1, 2'b10},
        '{6'd1, 1'b0, 2'b01},
        '{6'd2, 1'b1, 2'b10},
        '{6'd0, 1'b0, 2'b01}
    };

    function automatic logic [9:0] actual();
        return {cph1, cph2, cph3, sth1_o, sth1_oe, sth2_o, sth2_oe, inh, q2h, vcom_pol};
    endfunction

    // Expected port vector at position n from the requirements.
    function automatic logic [9:0] model(int n, int d, logic lr, logic pol);
        int s;
        int p;
        logic c1, c2, c3, st, en;
        s  = (n / d) % 6;
        p  = (n / (6 * d)) % LINE_LEN;
        c1 = (s <= 2);
        c2 = (s >= 2 && s <= 4);
        c3 = (s >= 4 || s == 0);
        st = (p == STH_POS - 1 && s >= 3) || (p == STH_POS && s <= 2);
        en = (p >= INH_START && p < INH_START + INH_LEN);
        return {c1, c2, c3, lr & st, lr, ~lr & st, ~lr, en, pol, pol};
    endfunction

    task automatic check_vec(string tag, logic [9:0] act, logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Raise sync; optionally keep it high. Returns on the falling edge after the detecting edge.
    task automatic start_line(logic hold);
        @(negedge clk) hd = 1'b1;
        lines++;
        @(negedge clk);
        if (!hold) hd = 1'b0;
    endtask

    // Compare every position from k0 for npos cycles against the model.
    task automatic walk(int k0, int npos, int d, logic lr, string tag);
        for (int k = k0; k < k0 + npos; k++) begin
            @(negedge clk);
            check_vec(tag, actual(), model(k, d, lr, (lines % 2) == 1));
        end
    endtask

    initial begin
        rst_n = 1'b0; hd = 1'b0; scan_lr = 1'b1; phase_len_m1 = '0;
        repeat (4) @(negedge clk);
        check_vec("R1 in reset", actual(), 10'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i % 5 == 0) check_vec("R1 idle before first hd", actual(), 10'b0);
        end

        // Table walk: full lines plus the wrap into the next line (R2 R3 R4 R5 R6 R7 R8).
        for (int i = 0; i < 4; i++) begin
            int d;
            d = int'(VECS[i].div_m1) + 1;
            scan_lr = VECS[i].lr;
            phase_len_m1 = VECS[i].div_m1;
            start_line(1'b0);
            walk(0, 6 * d * LINE_LEN + 12 * d, d, VECS[i].lr, "R2 R3 R4 R5 R6 R7 R8 table");
            check_int("R6 enables", int'({sth1_oe, sth2_oe}), int'(VECS[i].oe));
        end

        // R9: mid-line changes of direction and divider are ignored until the next line.
        scan_lr = 1'b1; phase_len_m1 = 6'd1;
        start_line(1'b0);
        walk(0, 40, 2, 1'b1, "R9 before change");
        scan_lr = 1'b0; phase_len_m1 = 6'd3;
        walk(40, 200, 2, 1'b1, "R9 after mid-line change");
        start_line(1'b0);
        walk(0, 120, 4, 1'b0, "R9 new line uses new settings");

        // R10: a held-high sync does not restart the line.
        scan_lr = 1'b1; phase_len_m1 = 6'd0;
        start_line(1'b1);
        walk(0, 300, 1, 1'b1, "R10 hd held high");
        hd = 1'b0;
        walk(300, 10, 1, 1'b1, "R10 hd falls");

        // R2: restart in the middle of a line.
        start_line(1'b0);
        walk(0, 250, 1, 1'b1, "R2 first part");
        start_line(1'b0);
        walk(0, 100, 1, 1'b1, "R2 after mid-line restart");

        // R3 / R5: measure phase spacing and start pulse width, right-to-left.
        begin
            int d, r1, r2, r3, sth_first, sth_cnt, pin1_hi;
            logic p1, p2, p3;
            d = 3; r1 = -1; r2 = -1; r3 = -1; sth_first = -1; sth_cnt = 0; pin1_hi = 0;
            scan_lr = 1'b0; phase_len_m1 = 6'd2;
            start_line(1'b0);
            @(negedge clk);
            p1 = cph1; p2 = cph2; p3 = cph3;
            for (int k = 1; k < (STH_POS + 2) * 6 * d; k++) begin
                @(negedge clk);
                if (cph1 && !p1 && r1 < 0) r1 = k;
                if (cph2 && !p2 && r2 < 0) r2 = k;
                if (cph3 && !p3 && r3 < 0) r3 = k;
                if (sth2_o) begin
                    if (sth_first < 0) sth_first = k;
                    sth_cnt++;
                end
                if (sth1_o) pin1_hi++;
                p1 = cph1; p2 = cph2; p3 = cph3;
            end
            check_int("R3 cph2 first rise", r2, 2 * d);
            check_int("R3 cph3 lags cph2", r3 - r2, 2 * d);
            check_int("R3 cph1 lags cph3", r1 - r3, 2 * d);
            check_int("R5 start pulse width", sth_cnt, 6 * d);
            check_int("R5 start pulse begin", sth_first, (STH_POS - 1) * 6 * d + 3 * d);
            check_int("R6 undriven pin stays low", pin1_hi, 0);
        end

        // R1: reset during a running line clears every output.
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_vec("R1 reset mid-line", actual(), 10'b0);
        lines = 0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_vec("R1 idle after second reset", actual(), 10'b0);
        scan_lr = 1'b1; phase_len_m1 = 6'd0;
        start_line(1'b0);
        walk(0, 30, 1, 1'b1, "R8 polarity restarts at one after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule